// File: doc/BRIEF.md
# Byte-Serial Register Write Deserializer

This block sits at the end of a narrow configuration bus. Register writes reach it one byte per clock: the low address byte comes first and is flagged by a strobe. The high address byte follows, and then the data bytes, least significant first. The block collects the bytes of a frame and compares the assembled address with a base address. The comparison covers only the bits that a mask selects. On a match, the block issues a one-clock write pulse together with the low bits of the address and the full data word. A frame whose address does not match produces no pulse and leaves the outputs unchanged.

Several of these blocks can share one bus, each with its own base and mask. The bits cleared in the mask pick a register inside the owning block. With the default base 0x0100 and mask 0x03E0, a frame is accepted when address bits 9:5 equal 5'b01000. Bits 15:10 and 4:0 play no part in the match, and bits 4:0 appear as the local address.

Top module: `regwr_deser`

## Requirements
- R1: A frame is six consecutive bytes, one per clock. The strobe is high only with the first byte. The byte order is address bits 7:0, address bits 15:8, then data bytes 0 to 3.
- R2: Data is assembled little-endian: data byte 0 lands on bits 7:0 and data byte 3 on bits 31:24 of `wr_data`.
- R3: A frame is accepted when (address AND MASK) equals (BASE AND MASK). On acceptance, `wr_addr` shows address bits 4:0 and `wr_data` shows the data word.
- R4: A frame that does not match raises no pulse, and `wr_addr` and `wr_data` keep the values of the last accepted frame.
- R5: `wr_en` is high for exactly one clock: the cycle after the clock edge that captures the sixth byte.
- R6: A strobe that arrives while a frame is in progress drops the partial frame. The strobed byte becomes the first byte of a new frame.
- R7: A synchronous reset clears the byte counter and sets `wr_en`, `wr_addr` and `wr_data` to zero. Bytes that follow without a strobe are ignored.
- R8: Frames may follow each other with no idle cycle between them, and each accepted frame gives its own pulse.
- R9: While no frame is in progress, bytes without a strobe are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| cmd_byte | input | 8 | Serial bus byte |
| cmd_stb | input | 1 | Marks the first byte of a frame |
| wr_addr | output | 5 | Local register address of the last accepted frame |
| wr_data | output | 32 | Data word of the last accepted frame |
| wr_en | output | 1 | One-clock write pulse |

## Verification
The bench sends addresses whose out-of-mask bits vary while the selecting bits stay fixed, and addresses that miss by a single bit. A wrong mask therefore either drops legal writes or accepts foreign ones. A design that updates its outputs on every frame fails the hold check after a miss. A one-cycle error in the counter shows up as a pulse in the wrong sample slot or as a swapped data byte. Three further cases are covered. A restart in the middle of a frame catches a design that completes the stale frame. Back-to-back frames catch a design that needs an idle gap. A reset during a frame catches a counter that resumes after reset.

// File: rtl/regwr_deser.sv
module regwr_deser #(
  parameter int ADDR_BYTES = 2,
  parameter int DATA_BYTES = 4,
  parameter int LOCAL_AW   = 5,
  parameter logic [8*ADDR_BYTES-1:0] BASE = 16'h0100,
  parameter logic [8*ADDR_BYTES-1:0] MASK = 16'h03E0
) (
  input  logic                    clk,
  input  logic                    srst,
  input  logic [7:0]              cmd_byte,
  input  logic                    cmd_stb,
  output logic [LOCAL_AW-1:0]     wr_addr,
  output logic [8*DATA_BYTES-1:0] wr_data,
  output logic                    wr_en
);
  localparam int BYTES = ADDR_BYTES + DATA_BYTES;
  localparam int AW    = 8 * ADDR_BYTES;
  localparam int HW    = 8 * (BYTES - 1);
  localparam int CW    = $clog2(BYTES);

  logic [CW-1:0]      cnt;
  logic [HW-1:0]      hold;
  logic [8*BYTES-1:0] frame;
  logic [AW-1:0]      addr;
  logic               last, hit;

  assign frame = {cmd_byte, hold};
  assign addr  = frame[AW-1:0];
  assign last  = !cmd_stb && (cnt == CW'(BYTES - 1));
  assign hit   = ((addr ^ BASE) & MASK) == '0;

  always_ff @(posedge clk) begin
    if (srst)                cnt <= '0;
    else if (cmd_stb)        cnt <= CW'(1);
    else if (last)           cnt <= '0;
    else if (cnt != '0)      cnt <= cnt + CW'(1);
  end

  always_ff @(posedge clk)
    hold <= {cmd_byte, hold[HW-1:8]};

  always_ff @(posedge clk) begin
    if (srst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= last && hit;
      if (last && hit) begin
        wr_addr <= addr[LOCAL_AW-1:0];
        wr_data <= frame[8*BYTES-1:AW];
      end
    end
  end

  logic rst_d;
  always_ff @(posedge clk) rst_d <= srst;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (srst)
    wr_en |=> !wr_en); // R5
  AST_PULSE_AFTER_LAST: assert property (@(posedge clk) disable iff (srst)
    (wr_en && !rst_d) |-> $past(cnt == CW'(BYTES - 1) && !cmd_stb)); // R5
  AST_STB_RESTART: assert property (@(posedge clk) disable iff (srst)
    cmd_stb |=> (cnt == CW'(1))); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst_d |-> (cnt == '0 && !wr_en && wr_addr == '0)); // R7
  AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (srst)
    (cnt == '0 && !cmd_stb && !rst_d) |=> (cnt == '0)); // R9
  AST_HOLD_NO_PULSE: assert property (@(posedge clk) disable iff (srst)
    (!wr_en && !rst_d) |-> ($stable(wr_addr) && $stable(wr_data))); // R4
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (srst)
    cnt < CW'(BYTES)); // R1
endmodule

// File: tb/regwr_deser_test.sv
module regwr_deser_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {expected match, address, data}
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 16'h0100, 32'h1234_5678},
    {1'b0, 16'h0120, 32'hDEAD_BEEF},
    {1'b1, 16'h011F, 32'hA5A5_0F0F},
    {1'b0, 16'h0000, 32'h1111_1111},
    {1'b1, 16'hFD05, 32'h0102_0304},
    {1'b0, 16'h0300, 32'h2222_2222},
    {1'b1, 16'h0903, 32'hFFFF_0000},
    {1'b0, 16'h0080, 32'h3333_3333}
  };

  logic clk = 1'b0, srst = 1'b1, cmd_stb = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [4:0] wr_addr;
  logic [31:0] wr_data;
  logic wr_en;
  int checks = 0, fails = 0, npulse = 0;
  logic [4:0] log_a [32];
  logic [31:0] log_d [32];
  logic [4:0] exp_a;
  logic [31:0] exp_d;

  regwr_deser uut (.clk(clk), .srst(srst), .cmd_byte(cmd_byte), .cmd_stb(cmd_stb),
                   .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (wr_en) begin
    log_a[npulse % 32] <= wr_addr;
    log_d[npulse % 32] <= wr_data;
    npulse <= npulse + 1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic stb, input logic [7:0] b);
    @(negedge clk);
    cmd_stb = stb;
    cmd_byte = b;
  endtask

  task automatic send(input logic [15:0] a, input logic [31:0] d);
    put(1'b1, a[7:0]);
    put(1'b0, a[15:8]);
    for (int i = 0; i < 4; i++) put(1'b0, d[8*i +: 8]);
  endtask

  task automatic settle;
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    exp_a = '0; exp_d = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R7 reset en", 64'(wr_en), 64'(0));
    check("R7 reset addr", 64'(wr_addr), 64'(0));
    check("R7 reset data", 64'(wr_data), 64'(0));
    srst = 1'b0;

    // R9: stray bytes while idle
    for (int i = 0; i < 8; i++) put(1'b0, 8'h40 + 8'(i));
    settle();
    check("R9 idle bytes no pulse", 64'(npulse), 64'(0));

    // R1 R2 R3 R4 R5: table walk
    for (int v = 0; v < NV; v++) begin
      int n0;
      n0 = npulse;
      send(VEC[v][47:32], VEC[v][31:0]);
      if (VEC[v][48]) begin exp_a = VEC[v][36:32]; exp_d = VEC[v][31:0]; end
      settle();
      check(VEC[v][48] ? "R3 match pulse" : "R4 miss no pulse", 64'(wr_en), 64'(VEC[v][48]));
      check("R3 R4 addr", 64'(wr_addr), 64'(exp_a));
      check("R2 data", 64'(wr_data), 64'(exp_d));
      settle();
      check("R5 pulse one cycle", 64'(wr_en), 64'(0));
      check("R5 pulse count", 64'(npulse - n0), 64'(VEC[v][48]));
    end

    // R6: restart mid-frame
    begin
      int n0;
      n0 = npulse;
      put(1'b1, 8'h00); put(1'b0, 8'h01); put(1'b0, 8'hEE);
      send(16'h0107, 32'hCAFE_F00D);
      settle(); settle();
      check("R6 restart count", 64'(npulse - n0), 64'(1));
      check("R6 restart addr", 64'(wr_addr), 64'(7));
      check("R6 restart data", 64'(wr_data), 64'(32'hCAFE_F00D));
    end

    // R8: back-to-back
    begin
      int n0;
      n0 = npulse;
      send(16'h0109, 32'h0A0B_0C0D);
      send(16'h0112, 32'h5566_7788);
      settle(); settle();
      check("R8 b2b count", 64'(npulse - n0), 64'(2));
      check("R8 b2b first addr", 64'(log_a[n0 % 32]), 64'(9));
      check("R8 b2b first data", 64'(log_d[n0 % 32]), 64'(32'h0A0B_0C0D));
      check("R8 b2b second addr", 64'(log_a[(n0 + 1) % 32]), 64'(5'h12));
      check("R8 b2b second data", 64'(log_d[(n0 + 1) % 32]), 64'(32'h5566_7788));
    end

    // R7: reset during a frame
    begin
      int n0;
      n0 = npulse;
      put(1'b1, 8'h04); put(1'b0, 8'h01); put(1'b0, 8'h99);
      @(negedge clk); srst = 1'b1; cmd_byte = 8'h98;
      @(negedge clk); srst = 1'b0; cmd_byte = 8'h97;
      put(1'b0, 8'h96); put(1'b0, 8'h95); put(1'b0, 8'h94);
      settle(); settle();
      check("R7 reset mid-frame no pulse", 64'(npulse - n0), 64'(0));
      check("R7 reset mid-frame addr", 64'(wr_addr), 64'(0));
      check("R7 reset mid-frame data", 64'(wr_data), 64'(0));
      send(16'h0101, 32'h0000_00AB);
      settle();
      check("R7 accepts after reset", 64'(wr_en), 64'(1));
      check("R1 addr after reset", 64'(wr_addr), 64'(1));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule